// File: doc/BRIEF.md
# Fragment Depth Stencil Blend Unit

This block is the last stage of a small raster pipeline. It accepts one shaded fragment per transaction (pixel coordinates, a depth value, an RGB color and an alpha value) and resolves it against per-pixel state held on chip for a tiny frame, 16x16 pixels by default. The tests always run in the same order. First an alpha compare against a reference. Then a masked stencil compare against the stored stencil value. Then a depth compare against the stored depth. Only a fragment that clears every enabled test touches the frame. Such a fragment writes its depth and writes a color that either replaces the stored color or blends with it by the fragment alpha.

Each compare is set by a 3-bit function code, so the depth rule can change between draws. The settings are captured together with the fragment, so they may change on the cycle right after a handshake. Each fragment takes two cycles: one to read the pixel and one to write it. The input handshake stalls while a fragment is in flight, so two fragments can never touch one pixel at the same time. A clear walks the whole frame once, one pixel per cycle. It runs by itself after reset and again on request. While it runs, no fragments are accepted. A combinational readback port returns the stored depth, stencil and color of any pixel.

Top module: `fdsb_unit`

## Requirements
- R1: After reset is released, `frag_ready_o` stays low for exactly NPIX clock cycles (NPIX = 2^(XW+YW)). During that time every pixel is set to depth all-ones, stencil `clr_stencil_i` and color `clr_color_i`.
- R2: `clear_i` high while the unit is idle forces `frag_ready_o` low in that same cycle. It starts the same NPIX-cycle clear with the current clear values, and any fragment offered in that cycle is not taken.
- R3: A fragment that fails any enabled test holds `upd_o` low and leaves the pixel's depth, stencil and color unchanged.
- R4: The alpha test compares the fragment alpha (`frag_rgba_i[7:0]`) against `alpha_ref_i` as `alpha FN ref`. The function codes are: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always.
- R5: The stencil test evaluates `(sten_ref_i & sten_mask_i) FN (stored & sten_mask_i)` with the same function codes. Stored stencil values change only through a clear.
- R6: The depth test evaluates `frag_z_i FN stored` with the same codes, so code 1 passes when the fragment is nearer. On an update the stored depth becomes `frag_z_i`.
- R7: A test whose enable input is low always passes.
- R8: On an update with `blend_en_i` low, the stored color (R at bits 23:16, G at 15:8, B at 7:0) becomes `frag_rgba_i[31:8]`. With `blend_en_i` high, each channel becomes (s*a + d*(255-a) + 127) / 255, rounded down, where s is the fragment channel, d the stored channel and a the alpha.
- R9: In the cycle after a handshake, `frag_ready_o` is low, and `upd_o` is high exactly when the fragment passes. The pixel's stored values change at the next clock edge.
- R10: `rd_depth_o`, `rd_stencil_o` and `rd_color_o` show, without delay, the stored values of the pixel at address {`rd_y_i`, `rd_x_i`}. A fragment's pixel address is {`frag_y_i`, `frag_x_i`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frag_valid_i | input | 1 | Fragment offered |
| frag_ready_o | output | 1 | Fragment can be taken this cycle |
| frag_x_i | input | XW | Pixel column |
| frag_y_i | input | YW | Pixel row |
| frag_z_i | input | ZW | Fragment depth |
| frag_rgba_i | input | 4*CW | {R,G,B,alpha} |
| alpha_en_i | input | 1 | Alpha test enable |
| alpha_fn_i | input | 3 | Alpha compare function |
| alpha_ref_i | input | CW | Alpha reference |
| sten_en_i | input | 1 | Stencil test enable |
| sten_fn_i | input | 3 | Stencil compare function |
| sten_ref_i | input | SW | Stencil reference |
| sten_mask_i | input | SW | Stencil compare mask |
| depth_en_i | input | 1 | Depth test enable |
| depth_fn_i | input | 3 | Depth compare function |
| blend_en_i | input | 1 | Alpha blend instead of replace |
| clear_i | input | 1 | Start a frame clear |
| clr_stencil_i | input | SW | Stencil clear value |
| clr_color_i | input | 3*CW | Color clear value |
| upd_o | output | 1 | Pixel update in this cycle |
| rd_x_i | input | XW | Readback column |
| rd_y_i | input | YW | Readback row |
| rd_depth_o | output | ZW | Stored depth at readback pixel |
| rd_stencil_o | output | SW | Stored stencil at readback pixel |
| rd_color_o | output | 3*CW | Stored color at readback pixel |

## Verification
A wrong compare decision shows up on `upd_o` in the cycle after the handshake. The pixel readback confirms it one cycle later, because the stored depth or color then differs from the value the model predicts. A broken clear walk shows as a wrong `frag_ready_o` count, or as stale pixels found in the full-frame sweep that follows every clear. Fragments aimed at a few pixels with random settings make each stored value feed the next compare, so one bad write is exposed by the next fragment on that pixel.

// File: rtl/fdsb_pkg.sv
package fdsb_pkg;
  typedef enum logic [2:0] {
    CMP_NEVER  = 3'd0,
    CMP_LT     = 3'd1,
    CMP_EQ     = 3'd2,
    CMP_LE     = 3'd3,
    CMP_GT     = 3'd4,
    CMP_NE     = 3'd5,
    CMP_GE     = 3'd6,
    CMP_ALWAYS = 3'd7
  } cmp_fn_e;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_EXEC  = 2'd2
  } st_e;
endpackage

// File: rtl/fdsb_cmp.sv
module fdsb_cmp import fdsb_pkg::*; #(
  parameter int W = 8
) (
  input  logic         en_i,
  input  cmp_fn_e      fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         pass_o
);
  logic res;

  always_comb begin
    unique case (fn_i)
      CMP_NEVER:  res = 1'b0;
      CMP_LT:     res = a_i <  b_i;
      CMP_EQ:     res = a_i == b_i;
      CMP_LE:     res = a_i <= b_i;
      CMP_GT:     res = a_i >  b_i;
      CMP_NE:     res = a_i != b_i;
      CMP_GE:     res = a_i >= b_i;
      CMP_ALWAYS: res = 1'b1;
    endcase
    pass_o = !en_i || res;
  end
endmodule

// File: rtl/fdsb_blend.sv
module fdsb_blend #(
  parameter int NCH = 3,
  parameter int CW  = 8
) (
  input  logic              mode_i,
  input  logic [CW-1:0]     alpha_i,
  input  logic [NCH*CW-1:0] src_i,
  input  logic [NCH*CW-1:0] dst_i,
  output logic [NCH*CW-1:0] out_o
);
  localparam int AW = 2*CW + 1;
  localparam logic [CW-1:0] AMAX = '1;
  localparam logic [AW-1:0] DIV  = AW'(AMAX);
  localparam logic [AW-1:0] HALF = AW'(AMAX >> 1);

  logic [CW-1:0] inv_a;
  assign inv_a = AMAX - alpha_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] s, d, mix;
    logic [AW-1:0] acc;
    assign s   = src_i[c*CW +: CW];
    assign d   = dst_i[c*CW +: CW];
    assign acc = AW'(s) * AW'(alpha_i) + AW'(d) * AW'(inv_a) + HALF;
    assign mix = CW'(acc / DIV);
    assign out_o[c*CW +: CW] = mode_i ? mix : s;
  end
endmodule

// File: rtl/fdsb_store.sv
module fdsb_store #(
  parameter int AW = 8,
  parameter int ZW = 16,
  parameter int SW = 8,
  parameter int PW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sten_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [ZW-1:0] wr_z_i,
  input  logic [SW-1:0] wr_s_i,
  input  logic [PW-1:0] wr_c_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [ZW-1:0] ra_z_o,
  output logic [SW-1:0] ra_s_o,
  output logic [PW-1:0] ra_c_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [ZW-1:0] rb_z_o,
  output logic [SW-1:0] rb_s_o,
  output logic [PW-1:0] rb_c_o
);
  localparam int NPIX = 1 << AW;

  logic [ZW-1:0] z_mem [NPIX];
  logic [SW-1:0] s_mem [NPIX];
  logic [PW-1:0] c_mem [NPIX];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      z_mem[wr_addr_i] <= wr_z_i;
      c_mem[wr_addr_i] <= wr_c_i;
      if (wr_sten_i) s_mem[wr_addr_i] <= wr_s_i;
    end
  end

  assign ra_z_o = z_mem[ra_addr_i];
  assign ra_s_o = s_mem[ra_addr_i];
  assign ra_c_o = c_mem[ra_addr_i];
  assign rb_z_o = z_mem[rb_addr_i];
  assign rb_s_o = s_mem[rb_addr_i];
  assign rb_c_o = c_mem[rb_addr_i];

  p_write_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (z_mem[$past(wr_addr_i)] == $past(wr_z_i)) &&
                (c_mem[$past(wr_addr_i)] == $past(wr_c_i)));

  p_sten_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sten_i) |=> s_mem[$past(wr_addr_i)] == $past(s_mem[wr_addr_i]));
endmodule

// File: rtl/fdsb_unit.sv
module fdsb_unit import fdsb_pkg::*; #(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int ZW = 16,
  parameter int SW = 8,
  parameter int CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frag_valid_i,
  output logic              frag_ready_o,
  input  logic [XW-1:0]     frag_x_i,
  input  logic [YW-1:0]     frag_y_i,
  input  logic [ZW-1:0]     frag_z_i,
  input  logic [4*CW-1:0]   frag_rgba_i,
  input  logic              alpha_en_i,
  input  logic [2:0]        alpha_fn_i,
  input  logic [CW-1:0]     alpha_ref_i,
  input  logic              sten_en_i,
  input  logic [2:0]        sten_fn_i,
  input  logic [SW-1:0]     sten_ref_i,
  input  logic [SW-1:0]     sten_mask_i,
  input  logic              depth_en_i,
  input  logic [2:0]        depth_fn_i,
  input  logic              blend_en_i,
  input  logic              clear_i,
  input  logic [SW-1:0]     clr_stencil_i,
  input  logic [3*CW-1:0]   clr_color_i,
  output logic              upd_o,
  input  logic [XW-1:0]     rd_x_i,
  input  logic [YW-1:0]     rd_y_i,
  output logic [ZW-1:0]     rd_depth_o,
  output logic [SW-1:0]     rd_stencil_o,
  output logic [3*CW-1:0]   rd_color_o
);
  localparam int NCH = 3;
  localparam int AW  = XW + YW;
  localparam int PW  = NCH * CW;

  st_e            st;
  logic [AW-1:0]  clr_cnt;
  logic           accept;

  // fragment and settings captured at the handshake
  logic [AW-1:0]  f_addr;
  logic [ZW-1:0]  f_z;
  logic [PW-1:0]  f_rgb;
  logic [CW-1:0]  f_a;
  logic           q_aen, q_sen, q_zen, q_blend;
  cmp_fn_e        q_afn, q_sfn, q_zfn;
  logic [CW-1:0]  q_aref;
  logic [SW-1:0]  q_sref, q_smask;

  logic [ZW-1:0]  s_z;
  logic [SW-1:0]  s_s;
  logic [PW-1:0]  s_c;
  logic           a_pass, s_pass, z_pass, pass;
  logic [PW-1:0]  blend_c;

  logic           wr_en, wr_sten;
  logic [AW-1:0]  wr_addr;
  logic [ZW-1:0]  wr_z;
  logic [PW-1:0]  wr_c;

  assign frag_ready_o = (st == ST_IDLE) && !clear_i;
  assign accept       = frag_valid_i && frag_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_CLEAR;
      clr_cnt <= '0;
    end else begin
      unique case (st)
        ST_CLEAR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == '1) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (clear_i) begin
            st      <= ST_CLEAR;
            clr_cnt <= '0;
          end else if (frag_valid_i) begin
            st <= ST_EXEC;
          end
        end
        ST_EXEC: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_addr  <= '0;
      f_z     <= '0;
      f_rgb   <= '0;
      f_a     <= '0;
      q_aen   <= 1'b0;
      q_sen   <= 1'b0;
      q_zen   <= 1'b0;
      q_blend <= 1'b0;
      q_afn   <= CMP_NEVER;
      q_sfn   <= CMP_NEVER;
      q_zfn   <= CMP_NEVER;
      q_aref  <= '0;
      q_sref  <= '0;
      q_smask <= '0;
    end else if (accept) begin
      f_addr  <= {frag_y_i, frag_x_i};
      f_z     <= frag_z_i;
      f_rgb   <= frag_rgba_i[4*CW-1:CW];
      f_a     <= frag_rgba_i[CW-1:0];
      q_aen   <= alpha_en_i;
      q_sen   <= sten_en_i;
      q_zen   <= depth_en_i;
      q_blend <= blend_en_i;
      q_afn   <= cmp_fn_e'(alpha_fn_i);
      q_sfn   <= cmp_fn_e'(sten_fn_i);
      q_zfn   <= cmp_fn_e'(depth_fn_i);
      q_aref  <= alpha_ref_i;
      q_sref  <= sten_ref_i;
      q_smask <= sten_mask_i;
    end
  end

  fdsb_cmp #(.W(CW)) u_alpha (
    .en_i(q_aen), .fn_i(q_afn), .a_i(f_a), .b_i(q_aref), .pass_o(a_pass)
  );

  fdsb_cmp #(.W(SW)) u_sten (
    .en_i(q_sen), .fn_i(q_sfn), .a_i(q_sref & q_smask), .b_i(s_s & q_smask),
    .pass_o(s_pass)
  );

  fdsb_cmp #(.W(ZW)) u_depth (
    .en_i(q_zen), .fn_i(q_zfn), .a_i(f_z), .b_i(s_z), .pass_o(z_pass)
  );

  // test order: alpha, stencil, depth; any failure kills the update
  assign pass  = (st == ST_EXEC) && a_pass && s_pass && z_pass;
  assign upd_o = pass;

  fdsb_blend #(.NCH(NCH), .CW(CW)) u_blend (
    .mode_i(q_blend), .alpha_i(f_a), .src_i(f_rgb), .dst_i(s_c), .out_o(blend_c)
  );

  always_comb begin
    if (st == ST_CLEAR) begin
      wr_en   = 1'b1;
      wr_sten = 1'b1;
      wr_addr = clr_cnt;
      wr_z    = '1;
      wr_c    = clr_color_i;
    end else begin
      wr_en   = pass;
      wr_sten = 1'b0;
      wr_addr = f_addr;
      wr_z    = f_z;
      wr_c    = blend_c;
    end
  end

  fdsb_store #(.AW(AW), .ZW(ZW), .SW(SW), .PW(PW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sten_i (wr_sten),
    .wr_addr_i (wr_addr),
    .wr_z_i    (wr_z),
    .wr_s_i    (clr_stencil_i),
    .wr_c_i    (wr_c),
    .ra_addr_i (f_addr),
    .ra_z_o    (s_z),
    .ra_s_o    (s_s),
    .ra_c_o    (s_c),
    .rb_addr_i ({rd_y_i, rd_x_i}),
    .rb_z_o    (rd_depth_o),
    .rb_s_o    (rd_stencil_o),
    .rb_c_o    (rd_color_o)
  );

  p_clear_blocks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CLEAR) |-> !frag_ready_o);

  p_clear_walk_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CLEAR && clr_cnt != '1) |=> (st == ST_CLEAR) && (clr_cnt == $past(clr_cnt) + 1'b1));

  p_clear_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> !accept);

  p_stall_after_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !frag_ready_o);

  p_upd_follows_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(accept));

  p_full_alpha_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass && q_blend && f_a == '1) |-> blend_c == f_rgb);

  p_zero_alpha_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass && q_blend && f_a == '0) |-> blend_c == s_c);

  p_fail_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_EXEC && !(a_pass && s_pass && z_pass)) |-> !wr_en);
endmodule

// File: tb/fdsb_unit_tb.sv
module fdsb_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 256;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frag_valid = 1'b0;
  logic        frag_ready;
  logic [3:0]  frag_x = '0, frag_y = '0;
  logic [15:0] frag_z = '0;
  logic [31:0] frag_rgba = '0;
  logic        alpha_en = 1'b0, sten_en = 1'b0, depth_en = 1'b1, blend_en = 1'b0;
  logic [2:0]  alpha_fn = 3'd7, sten_fn = 3'd7, depth_fn = 3'd1;
  logic [7:0]  alpha_ref = '0, sten_ref = '0, sten_mask = 8'hFF;
  logic        clear = 1'b0;
  logic [7:0]  clr_stencil = 8'h00;
  logic [23:0] clr_color = 24'h102030;
  logic        upd;
  logic [3:0]  rd_x = '0, rd_y = '0;
  logic [15:0] rd_depth;
  logic [7:0]  rd_stencil;
  logic [23:0] rd_color;

  int n_chk = 0;
  int n_fail = 0;

  int mz [NPIX];
  int ms [NPIX];
  int mc [NPIX];

  always #(CLK_PERIOD/2) clk = ~clk;

  fdsb_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .frag_valid_i(frag_valid), .frag_ready_o(frag_ready),
    .frag_x_i(frag_x), .frag_y_i(frag_y), .frag_z_i(frag_z), .frag_rgba_i(frag_rgba),
    .alpha_en_i(alpha_en), .alpha_fn_i(alpha_fn), .alpha_ref_i(alpha_ref),
    .sten_en_i(sten_en), .sten_fn_i(sten_fn), .sten_ref_i(sten_ref), .sten_mask_i(sten_mask),
    .depth_en_i(depth_en), .depth_fn_i(depth_fn), .blend_en_i(blend_en),
    .clear_i(clear), .clr_stencil_i(clr_stencil), .clr_color_i(clr_color),
    .upd_o(upd),
    .rd_x_i(rd_x), .rd_y_i(rd_y),
    .rd_depth_o(rd_depth), .rd_stencil_o(rd_stencil), .rd_color_o(rd_color)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit cmpf(input int fn, input int a, input int b);
    case (fn)
      0: return 1'b0;
      1: return a <  b;
      2: return a == b;
      3: return a <= b;
      4: return a >  b;
      5: return a != b;
      6: return a >= b;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int mix(input int s, input int d, input int a);
    int r = 0;
    for (int c = 0; c < 3; c++) begin
      int sc = (s >> (8*c)) & 255;
      int dc = (d >> (8*c)) & 255;
      int v = (sc*a + dc*(255-a) + 127) / 255;
      r |= v << (8*c);
    end
    return r;
  endfunction

  task automatic sweep(input string tag);
    int bad = 0;
    int ba = 0, be = 0;
    for (int p = 0; p < NPIX; p++) begin
      rd_x = 4'(p); rd_y = 4'(p >> 4);
      #1;
      if (int'(rd_depth) != mz[p] || int'(rd_stencil) != ms[p] || int'(rd_color) != mc[p]) begin
        if (bad == 0) begin ba = int'(rd_color); be = mc[p]; end
        bad++;
      end
    end
    chk(bad == 0, tag, "frame sweep color at first bad pixel", ba, be);
  endtask

  task automatic do_clear(input logic [7:0] s, input logic [23:0] c, input bit with_frag);
    int cyc = 0;
    @(negedge clk);
    clr_stencil = s; clr_color = c; clear = 1'b1;
    if (with_frag) begin frag_valid = 1'b1; frag_x = 4'd1; frag_y = 4'd1; frag_z = 16'd0; end
    #1;
    chk(frag_ready == 1'b0, "R2", "ready while clear requested", int'(frag_ready), 0);
    @(negedge clk);
    clear = 1'b0; frag_valid = 1'b0;
    while (!frag_ready && cyc < 10*NPIX) begin @(negedge clk); cyc++; end
    chk(cyc == NPIX, "R2", "clear cycles", cyc, NPIX);
    for (int p = 0; p < NPIX; p++) begin mz[p] = 16'hFFFF; ms[p] = int'(s); mc[p] = int'(c); end
    sweep("R2");
  endtask

  task automatic send(input int x, input int y, input int z, input int rgba, input string tag);
    int p = y*16 + x;
    int a = rgba & 255;
    int src = (rgba >> 8) & 24'hFFFFFF;
    bit ok;
    int nc;
    @(negedge clk);
    frag_x = 4'(x); frag_y = 4'(y); frag_z = 16'(z); frag_rgba = 32'(rgba);
    frag_valid = 1'b1;
    while (!frag_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    frag_valid = 1'b0;
    ok = (!alpha_en || cmpf(int'(alpha_fn), a, int'(alpha_ref))) &&
         (!sten_en  || cmpf(int'(sten_fn), int'(sten_ref & sten_mask), ms[p] & int'(sten_mask))) &&
         (!depth_en || cmpf(int'(depth_fn), z, mz[p]));
    chk(frag_ready == 1'b0, "R9", "ready after handshake", int'(frag_ready), 0);
    chk(upd == ok, tag, "upd_o", int'(upd), int'(ok));
    nc = blend_en ? mix(src, mc[p], a) : src;
    if (ok) begin mz[p] = z; mc[p] = nc; end
    rd_x = 4'(x); rd_y = 4'(y);
    @(negedge clk);
    chk(int'(rd_depth) == mz[p], tag, "R10 depth readback", int'(rd_depth), mz[p]);
    chk(int'(rd_color) == mc[p], tag, "R10 color readback", int'(rd_color), mc[p]);
    chk(int'(rd_stencil) == ms[p], "R5", "stencil untouched", int'(rd_stencil), ms[p]);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc = 0;
    repeat (3) @(negedge clk);
    chk(frag_ready == 1'b0, "R1", "ready in reset", int'(frag_ready), 0);
    rst_n = 1'b1;
    while (!frag_ready && cyc < 10*NPIX) begin @(negedge clk); cyc++; end
    chk(cyc == NPIX, "R1", "reset clear cycles", cyc, NPIX);
    for (int p = 0; p < NPIX; p++) begin mz[p] = 16'hFFFF; ms[p] = 0; mc[p] = 24'h102030; end
    sweep("R1");

    // depth less, replace
    send(2, 3, 16'h4000, 32'hAABBCC_80, "R6");
    send(2, 3, 16'h5000, 32'h112233_80, "R3");
    send(2, 3, 16'h4000, 32'h112233_80, "R6");
    depth_fn = 3'd3;
    send(2, 3, 16'h4000, 32'h445566_80, "R6");
    depth_fn = 3'd2;
    send(2, 3, 16'h3FFF, 32'h778899_80, "R3");
    depth_fn = 3'd4;
    send(2, 3, 16'h9000, 32'h0A0B0C_80, "R6");
    depth_fn = 3'd0;
    send(5, 5, 16'h0000, 32'h0A0B0C_80, "R6");
    depth_fn = 3'd7;
    send(5, 5, 16'hFFFF, 32'h0D0E0F_80, "R6");
    // depth disabled passes even when the compare would reject
    depth_fn = 3'd0; depth_en = 1'b0;
    send(6, 6, 16'hFFF0, 32'h123456_00, "R7");
    depth_en = 1'b1; depth_fn = 3'd1;

    // alpha test
    alpha_en = 1'b1; alpha_fn = 3'd6; alpha_ref = 8'h80;
    send(7, 0, 16'h1000, 32'h010203_7F, "R4");
    send(7, 0, 16'h1000, 32'h010203_80, "R4");
    alpha_fn = 3'd5;
    send(7, 1, 16'h1000, 32'h010203_80, "R4");
    alpha_en = 1'b0;

    // stencil with mask after clearing stencil to 0x5A
    do_clear(8'h5A, 24'h000000, 1'b0);
    sten_en = 1'b1; sten_fn = 3'd2; sten_mask = 8'h0F; sten_ref = 8'hFA;
    send(1, 1, 16'h2000, 32'h202020_FF, "R5");
    sten_ref = 8'h0B;
    send(1, 2, 16'h2000, 32'h202020_FF, "R5");
    sten_fn = 3'd4; sten_mask = 8'hF0; sten_ref = 8'h60;
    send(1, 3, 16'h2000, 32'h303030_FF, "R5");
    sten_en = 1'b0;

    // blending
    blend_en = 1'b1;
    send(9, 9, 16'h1000, 32'hFF8000_80, "R8");
    send(9, 9, 16'h0F00, 32'h102030_FF, "R8");
    send(9, 9, 16'h0E00, 32'hFFFFFF_00, "R8");
    send(9, 9, 16'h0D00, 32'h00FF7F_40, "R8");
    blend_en = 1'b0;

    // clear collides with an offered fragment
    do_clear(8'hC3, 24'hABCDEF, 1'b1);

    // random mixed settings on a few pixels
    for (int i = 0; i < 400; i++) begin
      alpha_en = 1'($urandom); alpha_fn = 3'($urandom); alpha_ref = 8'($urandom);
      sten_en = 1'($urandom); sten_fn = 3'($urandom);
      sten_ref = 8'($urandom); sten_mask = 8'($urandom);
      depth_en = ($urandom % 4) != 0; depth_fn = 3'($urandom);
      blend_en = 1'($urandom);
      send(int'($urandom % 3), int'($urandom % 3), int'($urandom & 16'hFFFF),
           int'($urandom), "R3");
      if (i == 200) do_clear(8'($urandom), 24'($urandom), 1'b0);
    end
    sweep("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule